// File: doc/BRIEF.md
# Multiplexed External Memory Bus Unit

This unit connects the core of a small 8-bit controller to external memory. The core issues one of three request kinds: an instruction fetch, a data read or a data write. Each request carries a 16-bit address, and a write also carries a data byte. The unit runs a fixed four-phase bus cycle for each request and returns a one-clock completion pulse. For reads, the captured byte is returned with that pulse.

The bus saves pins by sharing one byte-wide port. In the first half of a cycle this port carries the low address byte, and in the second half it carries the data byte. A dedicated port carries the high address byte for the whole cycle. An active-high address strobe marks the address half, so an external transparent latch can hold the low byte. Three active-low strobes mark the data half, one per request kind:

- a code-enable strobe for instruction fetches,
- a read strobe for data reads,
- a write strobe for data writes.

An active-low external-code input chooses where fetches go. When it is low, every fetch goes out on the bus. When it is high, fetches to the lowest 4K of code space are served on chip. Such a fetch completes in one clock and causes no bus activity.

Top module: `xmem_bus_unit`

## Requirements
- R1: A request (req_valid high at a clock edge) is accepted only when the unit is idle. A request presented while a cycle is in progress is ignored and causes no bus activity. After each completion pulse, at least one idle clock passes before the next address phase.
- R2: In the first clock after acceptance (the address phase):
  - ale is 1 and ad_oe is 1;
  - ad_out equals address bits 7:0;
  - all three strobes (psen_n, rd_n, wr_n) are high.
- R3: In the second clock (the latch phase):
  - ale is 0;
  - ad_oe stays 1 and ad_out still carries address bits 7:0;
  - all strobes stay high.
- R4: addr_hi equals address bits 15:8 in all four phases of an external cycle.
- R5: An external fetch (req_kind 0) drives psen_n low for exactly one clock, the third (the data phase). rd_n and wr_n stay high throughout.
- R6: A data read (req_kind 1) drives rd_n low for exactly one clock, the data phase. The port is released (ad_oe 0) in the data and release phases. The byte on ad_in at the clock edge that ends the data phase appears on rdata during the completion pulse. The same release and capture apply to an external fetch.
- R7: A data write (req_kind 2) drives wr_n low for exactly one clock, the data phase. ad_out carries the write byte with ad_oe 1 in the data phase and in the following release phase, so the data is still held after wr_n rises.
- R8: done is high for exactly one clock, the fourth clock (the release phase), and all strobes are high in that clock.
- R9: A fetch accepted while ext_access_n is 1 and the address is below 4096 is served on chip:
  - done is high in the first clock after acceptance;
  - ale stays 0, all strobes stay high and ad_oe stays 0.
- R10: A fetch takes a full external cycle in either of two cases: ext_access_n is 0 (at any address), or the address is 4096 or above. Data reads and writes are external whatever the state of ext_access_n.
- R11: While reset (rst_n low) is applied:
  - ale is 0, ad_oe is 0 and done is 0;
  - psen_n, rd_n and wr_n are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe from the core |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| ext_access_n | input | 1 | Low: all fetches go external |
| rdata | output | 8 | Byte captured by the last external read or fetch |
| done | output | 1 | One-clock completion pulse |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, sampled value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address strobe, active high |
| psen_n | output | 1 | Code-memory enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench goes after the 4K boundary: it fetches at 0x0FFF and at 0x1000, and a fetch below 4K with ext_access_n low. A unit with an off-by-one or an inverted external-code test would then run a bus cycle that should stay on chip, or skip one that must go out. A request is injected during a data phase, and a request is held for many clocks. Together these catch a unit that restarts mid-cycle or never rests between cycles; either fault shows as an early address strobe or a lost write. The external memory model reads the byte on the port as wr_n rises and reads the latched address, so a write that drops its data with the strobe is recorded as a corrupted store. Reads return an address-dependent byte, so capture on the wrong edge gives the wrong rdata.

// File: rtl/xmb_pkg.sv
`timescale 1ns/1ps
package xmb_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_DREAD  = 2'd1,
    KIND_DWRITE = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_DATA  = 3'd3,
    PH_REL   = 3'd4,
    PH_INT   = 3'd5
  } phase_e;

  // A fetch that stays on chip: external-code input high and address in range.
  function automatic logic hits_internal(logic [1:0] kind, logic [31:0] addr,
                                         logic ea_n, int unsigned limit);
    return (kind == KIND_FETCH) && ea_n && (addr < limit);
  endfunction

  function automatic logic kind_reads(logic [1:0] kind);
    return kind != KIND_DWRITE;
  endfunction

endpackage

// File: rtl/xmb_seq.sv
`timescale 1ns/1ps
module xmb_seq
  import xmb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_internal,
  output phase_e phase,
  output logic   accept,
  output logic   cyc_end
);

  phase_e phase_nx;

  assign accept  = req_valid && (phase == PH_IDLE);
  assign cyc_end = (phase == PH_REL) || (phase == PH_INT);

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (accept) phase_nx = req_internal ? PH_INT : PH_ADDR;
      PH_ADDR:  phase_nx = PH_LATCH;
      PH_LATCH: phase_nx = PH_DATA;
      PH_DATA:  phase_nx = PH_REL;
      PH_REL:   phase_nx = PH_IDLE;
      PH_INT:   phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/xmb_capture.sv
`timescale 1ns/1ps
module xmb_capture
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_e            phase,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [1:0]        r_kind,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] rdata
);

  logic rd_sample;
  assign rd_sample = (phase == PH_DATA) && kind_reads(r_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_kind  <= KIND_FETCH;
      r_addr  <= '0;
      r_wdata <= '0;
    end else if (accept) begin
      r_kind  <= req_kind;
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (rd_sample) rdata <= ad_in;
  end

endmodule

// File: rtl/xmb_pins.sv
`timescale 1ns/1ps
module xmb_pins
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  phase_e            phase,
  input  logic [1:0]        r_kind,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done
);

  logic is_wr;
  assign is_wr   = (r_kind == KIND_DWRITE);
  assign addr_hi = r_addr[ADDR_W-1:DATA_W];

  always_comb begin
    ale    = 1'b0;
    ad_oe  = 1'b0;
    ad_out = '0;
    psen_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    done   = 1'b0;
    case (phase)
      PH_ADDR: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = r_addr[DATA_W-1:0];
      end
      PH_LATCH: begin
        ad_oe  = 1'b1;
        ad_out = r_addr[DATA_W-1:0];
      end
      PH_DATA: begin
        ad_oe  = is_wr;
        ad_out = is_wr ? r_wdata : '0;
        psen_n = (r_kind != KIND_FETCH);
        rd_n   = !((r_kind == KIND_DREAD) || (r_kind == KIND_RSVD));
        wr_n   = !is_wr;
      end
      PH_REL: begin
        ad_oe  = is_wr;
        ad_out = is_wr ? r_wdata : '0;
        done   = 1'b1;
      end
      PH_INT:  done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/xmem_bus_unit.sv
`timescale 1ns/1ps
module xmem_bus_unit
  import xmb_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int INT_CODE_SIZE = 4096,
  localparam int HI_W         = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ext_access_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);

  phase_e            phase;
  logic              accept;
  logic              cyc_end;
  logic              req_internal;
  logic [1:0]        r_kind;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  assign req_internal = hits_internal(req_kind, 32'(req_addr), ext_access_n,
                                      INT_CODE_SIZE);

  xmb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_internal(req_internal), .phase(phase), .accept(accept),
    .cyc_end(cyc_end)
  );

  xmb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .r_kind(r_kind), .r_addr(r_addr), .r_wdata(r_wdata),
    .rdata(rdata)
  );

  logic done_w;

  xmb_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase(phase), .r_kind(r_kind), .r_addr(r_addr), .r_wdata(r_wdata),
    .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .done(done_w)
  );

  assign done = done_w && cyc_end;

endmodule

// File: rtl/xmb_chk.sv
`timescale 1ns/1ps
module xmb_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic [HI_W-1:0]   addr_hi,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              done
);

  logic any_strobe;
  assign any_strobe = !psen_n || !rd_n || !wr_n;

  p_gap_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ale);

  p_addr_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && psen_n && rd_n && wr_n));

  p_latch_then_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && !any_strobe) ##1 any_strobe);

  p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> $stable(addr_hi));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);

  p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!any_strobe ##1 !done));

endmodule

bind xmem_bus_unit xmb_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .ad_out(ad_out),
  .addr_hi(addr_hi), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
);

// File: tb/xmem_bus_unit_tb.sv
`timescale 1ns/1ps
module xmem_bus_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        ext_access_n = 1'b0;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic [7:0]  ad_in;
  logic        done, ad_oe, ale, psen_n, rd_n, wr_n;

  always #5 clk = ~clk;

  xmem_bus_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_access_n(ext_access_n),
    .rdata(rdata), .done(done), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string scn = "R11";

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] %s: got %0h expected %0h", tag, scn, what, got, exp);
    end
  endtask

  // external memory: transparent address latch and address-dependent contents
  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  logic [7:0] lat_lo = 8'h0;
  always @* if (ale) lat_lo = ad_out;
  assign ad_in = (!psen_n || !rd_n) ? mem_val({addr_hi, lat_lo}) : 8'hEE;

  logic [15:0] exp_waddr;
  logic [7:0]  exp_wdata;
  always @(posedge wr_n) if (rst_n) begin
    chk({addr_hi, lat_lo} == exp_waddr, "R7", "store address",
        int'({addr_hi, lat_lo}), int'(exp_waddr));
    chk(ad_out == exp_wdata, "R7", "store data", int'(ad_out), int'(exp_wdata));
  end

  // behavioural reference: a queue of expected per-clock pin values
  typedef struct {
    bit         act;
    bit         ale;
    bit         oe;
    logic [7:0] aout;
    bit         hchk;
    logic [7:0] hi;
    bit         psen_n;
    bit         rd_n;
    bit         wr_n;
    bit         done;
    bit         rchk;
    logic [7:0] rexp;
    string      tag;
  } frame_t;

  frame_t q[$];
  frame_t cur;

  function automatic frame_t idle_f();
    frame_t f;
    f.act = 0; f.ale = 0; f.oe = 0; f.aout = 0; f.hchk = 0; f.hi = 0;
    f.psen_n = 1; f.rd_n = 1; f.wr_n = 1; f.done = 0; f.rchk = 0; f.rexp = 0;
    f.tag = "R1";
    return f;
  endfunction

  task automatic push_req(logic [1:0] k, logic [15:0] a, logic [7:0] wd, bit ea_n);
    frame_t f;
    if (k == 2'd0 && ea_n && a < 16'd4096) begin
      f = idle_f(); f.act = 1; f.done = 1; f.tag = "R9";
      q.push_back(f);
      return;
    end
    f = idle_f(); f.act = 1; f.hchk = 1; f.hi = a[15:8];
    f.ale = 1; f.oe = 1; f.aout = a[7:0]; f.tag = "R2";
    q.push_back(f);
    f.ale = 0; f.tag = "R3";
    q.push_back(f);
    f.oe = (k == 2'd2); f.aout = wd;
    f.psen_n = (k != 2'd0); f.rd_n = (k != 2'd1); f.wr_n = (k != 2'd2);
    f.tag = (k == 2'd0) ? "R5" : (k == 2'd1) ? "R6" : "R7";
    q.push_back(f);
    f.psen_n = 1; f.rd_n = 1; f.wr_n = 1; f.done = 1;
    f.rchk = (k != 2'd2); f.rexp = mem_val(a); f.tag = "R8";
    q.push_back(f);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_f();
    end else begin
      if (!cur.act && req_valid) push_req(req_kind, req_addr, req_wdata, ext_access_n);
      if (q.size() > 0) cur = q.pop_front();
      else              cur = idle_f();
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(ale == cur.ale, cur.tag, "ale", int'(ale), int'(cur.ale));
    chk(ad_oe == cur.oe, cur.tag, "ad_oe", int'(ad_oe), int'(cur.oe));
    chk(psen_n == cur.psen_n, cur.tag, "psen_n", int'(psen_n), int'(cur.psen_n));
    chk(rd_n == cur.rd_n, cur.tag, "rd_n", int'(rd_n), int'(cur.rd_n));
    chk(wr_n == cur.wr_n, cur.tag, "wr_n", int'(wr_n), int'(cur.wr_n));
    chk(done == cur.done, cur.tag, "done", int'(done), int'(cur.done));
    if (cur.oe) chk(ad_out == cur.aout, cur.tag, "ad_out", int'(ad_out), int'(cur.aout));
    if (cur.hchk) chk(addr_hi == cur.hi, "R4", "addr_hi", int'(addr_hi), int'(cur.hi));
    if (cur.rchk) chk(rdata == cur.rexp, "R6", "rdata", int'(rdata), int'(cur.rexp));
  end

  task automatic send(string s, logic [1:0] k, logic [15:0] a, logic [7:0] wd,
                      bit ea_n, int hold);
    @(negedge clk);
    scn = s;
    req_kind = k; req_addr = a; req_wdata = wd; ext_access_n = ea_n;
    exp_waddr = a; exp_wdata = wd;
    req_valid = 1'b1;
    repeat (hold) @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur = idle_f();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ale == 1'b0, "R11", "ale in reset", int'(ale), 0);
    chk(ad_oe == 1'b0, "R11", "ad_oe in reset", int'(ad_oe), 0);
    chk(done == 1'b0, "R11", "done in reset", int'(done), 0);
    chk({psen_n, rd_n, wr_n} == 3'b111, "R11", "strobes in reset",
        int'({psen_n, rd_n, wr_n}), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send("R10", 2'd0, 16'h0123, 8'h00, 1'b0, 1);   // forced external fetch
    send("R9",  2'd0, 16'h0F00, 8'h00, 1'b1, 1);   // on-chip fetch
    send("R9",  2'd0, 16'h0FFF, 8'h00, 1'b1, 1);   // last on-chip address
    send("R10", 2'd0, 16'h1000, 8'h00, 1'b1, 1);   // first external address
    send("R6",  2'd1, 16'h8A3C, 8'h00, 1'b0, 1);
    send("R10", 2'd1, 16'h0010, 8'h00, 1'b1, 1);   // data read ignores ext_access_n
    send("R7",  2'd2, 16'h4455, 8'hC3, 1'b0, 1);
    send("R10", 2'd2, 16'h0200, 8'h96, 1'b1, 1);

    // R1: request injected during a read's data phase is ignored
    @(negedge clk);
    scn = "R1";
    req_kind = 2'd1; req_addr = 16'hBEEF; ext_access_n = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_kind = 2'd2; req_addr = 16'h7777; req_wdata = 8'h11;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);

    send("R1", 2'd0, 16'hABCD, 8'h00, 1'b0, 11);   // held request, back to back
    send("R9", 2'd0, 16'h0040, 8'h00, 1'b1, 4);    // held on-chip fetches
    send("R7", 2'd2, 16'hFFFF, 8'h5A, 1'b1, 1);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule